// File: doc/BRIEF.md
# PC Card Byte-Lane Steering Decoder

This block sits between a 16-bit PC Card host data bus and a bank of 8-bit memory segments. The segments come in pairs: one segment of each pair stores the even bytes and the other stores the odd bytes. A separate 8-bit attribute memory sits alongside them. From the two active-low card enables, address bit 0, the pair-select address bits, the attribute select and the output and write strobes, the block produces a chip select, an output enable and a write enable for each segment. It also drives the strobes of the attribute memory and the direction and byte-swap controls of the data transceiver, and it steers data both ways between the two host lanes and the segment buses.

The enable pair chooses the access width. With only the low enable active, the access is 8-bit on the low lane, and address bit 0 selects the even or the odd segment; an odd byte is swapped down onto the low lane. With only the high enable active, the odd byte is accessed on the high lane. With both enables active, the access is a full 16-bit word. Attribute accesses use the low lane and even bytes only. Every output is registered, so it reflects the inputs sampled at the previous rising clock edge.

Top module: `pccard_lane_steer`

## Requirements
- R1: With ce_lo_n and ce_hi_n both high (standby), every segment and attribute strobe is 0, both host lane enables are 0, xcvr_to_host is 0 and host_rdata is 0.
- R2: With ce_lo_n=0 and ce_hi_n=1 (byte mode), a0=0 selects only the even segment (index 2*pair) and a0=1 selects only the odd segment (index 2*pair+1). Reads return that segment's byte on host_rdata[7:0], and an odd byte asserts xcvr_swap. A write sends host_wdata[7:0] to seg_odd_wdata when a0=1. The high lane is never driven.
- R3: With ce_lo_n=1 and ce_hi_n=0 (high-only mode), only the odd segment of the pair is selected, whatever a0 is. Reads return its byte on host_rdata[15:8], the low lane is not driven and xcvr_swap is 0.
- R4: With both enables low (word mode), both segments of the pair are selected whatever a0 is. The even byte uses host_rdata[7:0] and the odd byte uses host_rdata[15:8], and writes send host_wdata[15:8] to seg_odd_wdata.
- R5: pair_sel picks segments 2*pair_sel and 2*pair_sel+1. No segment of another pair is selected.
- R6: Lanes are driven (host_lo_oe/host_hi_oe, xcvr_to_host=1) only when the card is selected, oe_n=0 and we_n=1. With oe_n=1, no lane is driven and undriven lanes of host_rdata read 0.
- R7: we_n=0 on a selected card raises seg_we on the selected segments and disables all lane drive, even when oe_n=0 too.
- R8: When wp=1, seg_we stays 0 while chip selects still follow the address.
- R9: attr_sel_n=0 deselects all segments. attr_cs rises for byte mode with a0=0 or for word mode, and reads drive attr_rdata on the low lane only. The high lane is never driven, and high-only mode selects nothing.
- R10: An attribute byte access with a0=1 keeps attr_cs, attr_oe and attr_we at 0. A read of it drives the parameter INVALID_FILL (default 8'hFF) on host_rdata[7:0].
- R11: Every output is registered one clock after its inputs, and synchronous active-high rst clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_lo_n | input | 1 | Low-lane card enable, active low |
| ce_hi_n | input | 1 | High-lane card enable, active low |
| attr_sel_n | input | 1 | Attribute space select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp | input | 1 | Write-protect, active high |
| a0 | input | 1 | Address bit 0 (even/odd byte) |
| pair_sel | input | PAIR_W | Segment pair select address bits |
| host_wdata | input | 2*BYTE_W | Write data from the host lanes |
| host_rdata | output | 2*BYTE_W | Read data toward the host, 0 on undriven lanes |
| host_lo_oe | output | 1 | Low lane drive enable |
| host_hi_oe | output | 1 | High lane drive enable |
| xcvr_to_host | output | 1 | Transceiver direction, 1 = card drives host |
| xcvr_swap | output | 1 | Transceiver byte swap, odd byte on low lane |
| seg_rdata | input | 2*NUM_PAIRS*BYTE_W | Read bytes of all segments, segment s at [s*BYTE_W +: BYTE_W] |
| seg_cs | output | 2*NUM_PAIRS | Segment chip selects |
| seg_oe | output | 2*NUM_PAIRS | Segment output enables |
| seg_we | output | 2*NUM_PAIRS | Segment write enables |
| seg_even_wdata | output | BYTE_W | Write byte for even segments |
| seg_odd_wdata | output | BYTE_W | Write byte for odd segments |
| attr_rdata | input | BYTE_W | Attribute memory read byte |
| attr_cs | output | 1 | Attribute memory select |
| attr_oe | output | 1 | Attribute memory output enable |
| attr_we | output | 1 | Attribute memory write enable |
| attr_wdata | output | BYTE_W | Attribute memory write byte |

## Verification
The bench sweeps every combination of the enables, a0, attribute select, both strobes, write-protect and pair select, with fresh data each time. Several corner cases get particular attention. An odd byte in byte mode must arrive on the low lane; a design that skipped the swap would return the even byte there. In high-only and word modes a0 is a don't-care; a decoder that let a0 through would drop a segment. When oe_n and we_n are both low, a correct design writes, so a wrong priority would drive the lanes during a write. Odd attribute addresses must return the fill byte with the attribute memory deselected, and a design that only gated the high lane would leak attribute data or strobe an odd write.

// File: rtl/pccard_lane_pkg.sv
package pccard_lane_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_BYTE = 2'd1,
    MODE_HIGH = 2'd2,
    MODE_WORD = 2'd3
  } lane_mode_e;

  typedef struct packed {
    lane_mode_e mode;
    logic       use_even;
    logic       use_odd;
    logic       swap;
    logic       attr;
    logic       attr_en;
    logic       attr_bad;
    logic       rd;
    logic       wr;
    logic       lo_drv;
    logic       hi_drv;
  } steer_dec_t;

endpackage

// File: rtl/lane_mode_decode.sv
module lane_mode_decode
  import pccard_lane_pkg::*;
(
  input  logic       ce_lo_n,
  input  logic       ce_hi_n,
  input  logic       attr_sel_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       a0,
  output steer_dec_t dec
);

  lane_mode_e mode;
  logic       active;
  logic       is_byte;
  logic       is_high;
  logic       is_word;

  always_comb begin
    unique case ({ce_hi_n, ce_lo_n})
      2'b10:   mode = MODE_BYTE;
      2'b01:   mode = MODE_HIGH;
      2'b00:   mode = MODE_WORD;
      default: mode = MODE_IDLE;
    endcase
  end

  assign active  = (mode != MODE_IDLE);
  assign is_byte = (mode == MODE_BYTE);
  assign is_high = (mode == MODE_HIGH);
  assign is_word = (mode == MODE_WORD);

  always_comb begin
    dec          = '0;
    dec.mode     = mode;
    dec.use_even = (is_byte && !a0) || is_word;
    dec.use_odd  = (is_byte && a0) || is_high || is_word;
    dec.swap     = is_byte && a0;
    dec.attr     = !attr_sel_n;
    // a write strobe wins over an output strobe when both are low
    dec.wr       = active && !we_n;
    dec.rd       = active && !oe_n && we_n;
    dec.attr_en  = !attr_sel_n && ((is_byte && !a0) || is_word);
    dec.attr_bad = !attr_sel_n && is_byte && a0;
    dec.lo_drv   = dec.rd && (is_byte || is_word);
    dec.hi_drv   = dec.rd && attr_sel_n && (is_high || is_word);
  end

endmodule

// File: rtl/seg_strobe_gen.sv
module seg_strobe_gen
  import pccard_lane_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  localparam int PAIR_W   = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int NUM_SEGS = 2 * NUM_PAIRS
) (
  input  steer_dec_t          dec,
  input  logic                wp,
  input  logic [PAIR_W-1:0]   pair_sel,
  output logic [NUM_SEGS-1:0] cs,
  output logic [NUM_SEGS-1:0] oe,
  output logic [NUM_SEGS-1:0] we
);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic pair_hit;
    assign pair_hit = !dec.attr && (pair_sel == PAIR_W'(p));

    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int S = 2 * p + h;
      logic sel;
      if (h == 0) begin : g_even
        assign sel = pair_hit && dec.use_even;
      end else begin : g_odd
        assign sel = pair_hit && dec.use_odd;
      end
      assign cs[S] = sel;
      assign oe[S] = sel && dec.rd;
      assign we[S] = sel && dec.wr && !wp;
    end
  end

endmodule

// File: rtl/lane_data_mux.sv
module lane_data_mux
  import pccard_lane_pkg::*;
#(
  parameter int                BYTE_W       = 8,
  parameter int                NUM_PAIRS    = 2,
  parameter logic [BYTE_W-1:0] INVALID_FILL = '1,
  localparam int PAIR_W   = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int NUM_SEGS = 2 * NUM_PAIRS,
  localparam int BUS_W    = 2 * BYTE_W
) (
  input  steer_dec_t                   dec,
  input  logic [PAIR_W-1:0]            pair_sel,
  input  logic [NUM_SEGS*BYTE_W-1:0]   seg_rdata,
  input  logic [BYTE_W-1:0]            attr_rdata,
  input  logic [BUS_W-1:0]             host_wdata,
  output logic [BUS_W-1:0]             rd_bus,
  output logic [BYTE_W-1:0]            even_wdata,
  output logic [BYTE_W-1:0]            odd_wdata,
  output logic [BYTE_W-1:0]            attr_wdata
);

  logic [BYTE_W-1:0] even_byte;
  logic [BYTE_W-1:0] odd_byte;
  logic [BYTE_W-1:0] lo_src;
  logic [BYTE_W-1:0] lo_lane_w;
  logic [BYTE_W-1:0] hi_lane_w;

  always_comb begin
    even_byte = '0;
    odd_byte  = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (pair_sel == PAIR_W'(p)) begin
        even_byte = seg_rdata[(2*p)*BYTE_W +: BYTE_W];
        odd_byte  = seg_rdata[(2*p+1)*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    if (dec.attr_bad)   lo_src = INVALID_FILL;
    else if (dec.attr)  lo_src = attr_rdata;
    else if (dec.swap)  lo_src = odd_byte;
    else                lo_src = even_byte;
  end

  assign lo_lane_w = dec.lo_drv ? lo_src   : '0;
  assign hi_lane_w = dec.hi_drv ? odd_byte : '0;
  assign rd_bus    = {hi_lane_w, lo_lane_w};

  assign even_wdata = host_wdata[BYTE_W-1:0];
  assign odd_wdata  = dec.swap ? host_wdata[BYTE_W-1:0] : host_wdata[BUS_W-1:BYTE_W];
  assign attr_wdata = host_wdata[BYTE_W-1:0];

endmodule

// File: rtl/pccard_lane_steer.sv
module pccard_lane_steer
  import pccard_lane_pkg::*;
#(
  parameter int                BYTE_W       = 8,
  parameter int                NUM_PAIRS    = 2,
  parameter logic [BYTE_W-1:0] INVALID_FILL = '1,
  localparam int PAIR_W   = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int NUM_SEGS = 2 * NUM_PAIRS,
  localparam int BUS_W    = 2 * BYTE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ce_lo_n,
  input  logic                       ce_hi_n,
  input  logic                       attr_sel_n,
  input  logic                       oe_n,
  input  logic                       we_n,
  input  logic                       wp,
  input  logic                       a0,
  input  logic [PAIR_W-1:0]          pair_sel,
  input  logic [BUS_W-1:0]           host_wdata,
  output logic [BUS_W-1:0]           host_rdata,
  output logic                       host_lo_oe,
  output logic                       host_hi_oe,
  output logic                       xcvr_to_host,
  output logic                       xcvr_swap,
  input  logic [NUM_SEGS*BYTE_W-1:0] seg_rdata,
  output logic [NUM_SEGS-1:0]        seg_cs,
  output logic [NUM_SEGS-1:0]        seg_oe,
  output logic [NUM_SEGS-1:0]        seg_we,
  output logic [BYTE_W-1:0]          seg_even_wdata,
  output logic [BYTE_W-1:0]          seg_odd_wdata,
  input  logic [BYTE_W-1:0]          attr_rdata,
  output logic                       attr_cs,
  output logic                       attr_oe,
  output logic                       attr_we,
  output logic [BYTE_W-1:0]          attr_wdata
);

  steer_dec_t          dec;
  logic [NUM_SEGS-1:0] cs_w;
  logic [NUM_SEGS-1:0] oe_w;
  logic [NUM_SEGS-1:0] we_w;
  logic [BUS_W-1:0]    rd_bus_w;
  logic [BYTE_W-1:0]   even_wd_w;
  logic [BYTE_W-1:0]   odd_wd_w;
  logic [BYTE_W-1:0]   attr_wd_w;

  lane_mode_decode u_decode (
    .ce_lo_n    (ce_lo_n),
    .ce_hi_n    (ce_hi_n),
    .attr_sel_n (attr_sel_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .a0         (a0),
    .dec        (dec)
  );

  seg_strobe_gen #(
    .NUM_PAIRS (NUM_PAIRS)
  ) u_strobe (
    .dec      (dec),
    .wp       (wp),
    .pair_sel (pair_sel),
    .cs       (cs_w),
    .oe       (oe_w),
    .we       (we_w)
  );

  lane_data_mux #(
    .BYTE_W       (BYTE_W),
    .NUM_PAIRS    (NUM_PAIRS),
    .INVALID_FILL (INVALID_FILL)
  ) u_mux (
    .dec        (dec),
    .pair_sel   (pair_sel),
    .seg_rdata  (seg_rdata),
    .attr_rdata (attr_rdata),
    .host_wdata (host_wdata),
    .rd_bus     (rd_bus_w),
    .even_wdata (even_wd_w),
    .odd_wdata  (odd_wd_w),
    .attr_wdata (attr_wd_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata     <= '0;
      host_lo_oe     <= 1'b0;
      host_hi_oe     <= 1'b0;
      xcvr_to_host   <= 1'b0;
      xcvr_swap      <= 1'b0;
      seg_cs         <= '0;
      seg_oe         <= '0;
      seg_we         <= '0;
      seg_even_wdata <= '0;
      seg_odd_wdata  <= '0;
      attr_cs        <= 1'b0;
      attr_oe        <= 1'b0;
      attr_we        <= 1'b0;
      attr_wdata     <= '0;
    end else begin
      host_rdata     <= rd_bus_w;
      host_lo_oe     <= dec.lo_drv;
      host_hi_oe     <= dec.hi_drv;
      xcvr_to_host   <= dec.lo_drv || dec.hi_drv;
      xcvr_swap      <= dec.swap;
      seg_cs         <= cs_w;
      seg_oe         <= oe_w;
      seg_we         <= we_w;
      seg_even_wdata <= even_wd_w;
      seg_odd_wdata  <= odd_wd_w;
      attr_cs        <= dec.attr_en;
      attr_oe        <= dec.attr_en && dec.rd;
      attr_we        <= dec.attr_en && dec.wr;
      attr_wdata     <= attr_wd_w;
    end
  end

endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int NUM_PAIRS = 2,
  localparam int NUM_SEGS = 2 * NUM_PAIRS
) (
  input logic                clk,
  input logic                rst,
  input logic                ce_lo_n,
  input logic                ce_hi_n,
  input logic                attr_sel_n,
  input logic                oe_n,
  input logic                we_n,
  input logic                wp,
  input logic                a0,
  input logic                host_lo_oe,
  input logic                host_hi_oe,
  input logic                xcvr_to_host,
  input logic                xcvr_swap,
  input logic [NUM_SEGS-1:0] seg_cs,
  input logic [NUM_SEGS-1:0] seg_we,
  input logic                attr_cs,
  input logic                attr_we
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(ce_lo_n && ce_hi_n) |-> (seg_cs == '0) && !attr_cs && !xcvr_to_host); // R1

  AST_BYTE_SINGLE_SEG: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!ce_lo_n && ce_hi_n) |-> ($countones(seg_cs) <= 1) && !host_hi_oe); // R2

  AST_HIGH_NO_LOW_LANE: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(ce_lo_n && !ce_hi_n) |-> !host_lo_oe && !xcvr_swap); // R3

  AST_PAIR_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $countones(seg_cs) <= 2); // R5

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(oe_n) |-> !host_lo_oe && !host_hi_oe); // R6

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!we_n) |-> !xcvr_to_host); // R7

  AST_WP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(wp) |-> (seg_we == '0)); // R8

  AST_ATTR_NO_SEG: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!attr_sel_n) |-> (seg_cs == '0) && !host_hi_oe); // R9

  AST_ATTR_ODD_OFF: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!attr_sel_n && !ce_lo_n && ce_hi_n && a0) |-> !attr_cs && !attr_we); // R10

endmodule

bind pccard_lane_steer lane_steer_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (.*);

// File: tb/tb_pccard_lane_steer.sv
module tb_pccard_lane_steer;

  localparam int BW  = 8;
  localparam int NP  = 2;
  localparam int NS  = 2 * NP;
  localparam logic [BW-1:0] FILL = 8'hFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_lo_n = 1'b1, ce_hi_n = 1'b1, attr_sel_n = 1'b1;
  logic oe_n = 1'b1, we_n = 1'b1, wp = 1'b0, a0 = 1'b0;
  logic [0:0]      pair_sel = '0;
  logic [2*BW-1:0] host_wdata = '0;
  logic [NS*BW-1:0] seg_rdata = '0;
  logic [BW-1:0]   attr_rdata = '0;

  logic [2*BW-1:0] host_rdata;
  logic host_lo_oe, host_hi_oe, xcvr_to_host, xcvr_swap;
  logic [NS-1:0] seg_cs, seg_oe, seg_we;
  logic [BW-1:0] seg_even_wdata, seg_odd_wdata, attr_wdata;
  logic attr_cs, attr_oe, attr_we;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pccard_lane_steer dut (
    .clk, .rst, .ce_lo_n, .ce_hi_n, .attr_sel_n, .oe_n, .we_n, .wp, .a0,
    .pair_sel, .host_wdata, .host_rdata, .host_lo_oe, .host_hi_oe,
    .xcvr_to_host, .xcvr_swap, .seg_rdata, .seg_cs, .seg_oe, .seg_we,
    .seg_even_wdata, .seg_odd_wdata, .attr_rdata, .attr_cs, .attr_oe,
    .attr_we, .attr_wdata
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of();
    bit bytem = !ce_lo_n && ce_hi_n;
    bit highm = ce_lo_n && !ce_hi_n;
    if (ce_lo_n && ce_hi_n) return "R1";
    if (!attr_sel_n) return (bytem && a0) ? "R10" : "R9";
    if (!we_n) return wp ? "R8" : "R7";
    if (oe_n) return "R6";
    if (bytem) return "R2";
    if (highm) return "R3";
    return "R4";
  endfunction

  // behavioural reference, evaluated on the inputs held over the last edge
  task automatic compare_all();
    bit bytem, highm, wordm, sel_any, want_even, want_odd, attr, rd, wr;
    bit lo_on, hi_on, attr_ok;
    logic [NS-1:0] e_cs, e_oe, e_we;
    logic [BW-1:0] ev, od, lo_b, hi_b, odd_w;
    string t, ts;
    bytem = !ce_lo_n && ce_hi_n;
    highm = ce_lo_n && !ce_hi_n;
    wordm = !ce_lo_n && !ce_hi_n;
    sel_any = bytem || highm || wordm;
    attr = !attr_sel_n;
    wr = sel_any && !we_n;
    rd = sel_any && !oe_n && we_n;
    want_even = wordm || (bytem && !a0);
    want_odd  = wordm || highm || (bytem && a0);
    e_cs = '0; e_oe = '0; e_we = '0;
    for (int s = 0; s < NS; s++) begin
      bit on;
      on = !attr && (pair_sel == (s / 2)) && ((s % 2 == 1) ? want_odd : want_even);
      e_cs[s] = on;
      e_oe[s] = on && rd;
      e_we[s] = on && wr && !wp;
    end
    ev = seg_rdata[(2*pair_sel)*BW +: BW];
    od = seg_rdata[(2*pair_sel+1)*BW +: BW];
    lo_on = rd && (bytem || wordm);
    hi_on = rd && !attr && (highm || wordm);
    attr_ok = attr && (wordm || (bytem && !a0));
    lo_b = 8'h00;
    if (lo_on) begin
      if (attr) lo_b = (bytem && a0) ? FILL : attr_rdata;
      else      lo_b = (bytem && a0) ? od : ev;
    end
    hi_b = hi_on ? od : 8'h00;
    odd_w = (bytem && a0) ? host_wdata[7:0] : host_wdata[15:8];
    t = tag_of();
    ts = (t == "R1" || t == "R9" || t == "R10") ? t : "R5";
    check(ts, "select", 64'({seg_cs, attr_cs}), 64'({e_cs, attr_ok}));
    check(t, "strobe",
          64'({seg_oe, seg_we, attr_oe, attr_we, host_lo_oe, host_hi_oe, xcvr_to_host, xcvr_swap}),
          64'({e_oe, e_we, attr_ok && rd, attr_ok && wr, lo_on, hi_on, lo_on || hi_on, bytem && a0}));
    check(t, "data",
          64'({host_rdata, seg_even_wdata, seg_odd_wdata, attr_wdata}),
          64'({hi_b, lo_b, host_wdata[7:0], odd_w, host_wdata[7:0]}));
  endtask

  task automatic check_cleared(input string what);
    check("R11", what,
          64'({host_rdata, host_lo_oe, host_hi_oe, xcvr_to_host, xcvr_swap,
               seg_cs, seg_oe, seg_we, seg_even_wdata, seg_odd_wdata,
               attr_cs, attr_oe, attr_we, attr_wdata}), 64'd0);
  endtask

  task automatic randomize_data();
    host_wdata = 16'($urandom);
    seg_rdata  = 32'($urandom);
    attr_rdata = 8'($urandom);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    @(negedge clk);
    // reset held with an active read pattern presented
    ce_lo_n = 1'b0; ce_hi_n = 1'b0; oe_n = 1'b0; host_wdata = 16'hA55A;
    seg_rdata = 32'h1234_5678;
    @(posedge clk);
    @(negedge clk);
    check_cleared("reset state");
    rst = 1'b0;
    step();

    // exhaustive control sweep, twice with fresh data
    for (int rep = 0; rep < 2; rep++) begin
      for (int v = 0; v < 256; v++) begin
        {ce_lo_n, ce_hi_n, a0, attr_sel_n, oe_n, we_n, wp} = 7'(v);
        pair_sel = 1'(v >> 7);
        randomize_data();
        step();
      end
    end

    // random phase
    for (int k = 0; k < 300; k++) begin
      {ce_lo_n, ce_hi_n, a0, attr_sel_n, oe_n, we_n, wp, pair_sel} = 8'($urandom);
      randomize_data();
      step();
    end

    // mid-run reset with a write pattern presented
    ce_lo_n = 1'b0; ce_hi_n = 1'b0; we_n = 1'b0; wp = 1'b0; attr_sel_n = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_cleared("mid-run reset");
    rst = 1'b0;
    step();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule